// File: doc/BRIEF.md
# Indirect codec register file

This block is the control register space of an audio codec, seen from a simple 32-bit read/write bus. The bus carries a byte address inside a 64-byte window. Bits [5:2] of that address pick one of sixteen 32-bit direct words. A second bank of thirty-two 8-bit indirect registers sits behind a pointer-and-port pair. Software writes the index into direct word 0 and then moves data through direct word 1.

Some locations have fixed access rules. One indirect register cannot be read back. Two indirect registers cannot be written. One indirect register keeps a fixed version code and lets software change only one bit. Direct word 2 cannot be written. Direct word 4 carries a software reset bit. A write that sets this bit returns the whole register space to its reset state, and the same write is then stored in word 4. The interrupt output exists for system wiring and stays inactive.

Top module: `codec_regfile`

## Requirements
- R1: The word select is addr[5:2]. Direct words 0, 3 and 5 to 15 store all 32 bits of a write, and a later read of the same word returns that value.
- R2: The indirect index is bits [4:0] of direct word 0. A write at word 1 stores wdata[7:0] into the indexed indirect register. A read at word 1 returns that register zero-extended to 32 bits. Direct word 0 itself keeps all 32 written bits.
- R3: A read at word 1 while the index is 3 returns zero.
- R4: Writes at word 1 are ignored while the index is 11 or 25.
- R5: A write at word 1 while the index is 12 stores (wdata[7:0] AND 0x40) OR 0x8A, so the register only ever holds 0x8A or 0xCA.
- R6: After rst_n is asserted, every direct word and every indirect register reads zero, except indirect 12, which reads 0x8A, and indirect 25, which reads 0xA0. rdata is zero.
- R7: Writes to direct word 2 are ignored, and reads of word 2 return zero.
- R8: A write to word 4 stores wdata AND 0x7F. If wdata[0] is 1, every other register returns to its R6 value on that same clock edge. Word 4 still keeps the masked written value.
- R9: rdata is registered. It takes the selected value on the clock edge that samples rd_en and holds it while rd_en is low. A read and a write to the same word in the same cycle return the value held before the write.
- R10: irq_o is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 6 | Byte address in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt line, held low |

## Verification
All stored state changes on the clock edge that samples wr_en, so a software reset and its capture into word 4 both show on a read issued in the very next cycle. Read data appears one edge after rd_en. The bench sets each strobe just after a falling edge, lowers it after the next rising edge, and samples rdata at the falling edge that follows. The read-during-write case and the hold-after-idle case are sampled at the same point, which separates old from new values.

// File: rtl/codec_rf_pkg.sv
// Shared constants for the codec register file: special word numbers,
// special indirect indices, fixed codes and masks.
package codec_rf_pkg;
    localparam int WORD_INDEX = 0;     // holds the indirect index
    localparam int WORD_DATA  = 1;     // data port to the indirect bank
    localparam int WORD_RO    = 2;     // ignores writes
    localparam int WORD_CTL   = 4;     // control word with software reset in bit 0

    localparam int IDX_WO     = 3;     // reads back as zero
    localparam int IDX_RO_A   = 11;    // ignores writes
    localparam int IDX_VER    = 12;    // fixed codec version code
    localparam int IDX_RO_B   = 25;    // fixed chip version, ignores writes

    localparam logic [7:0] CODEC_VER  = 8'h8A;
    localparam logic [7:0] CHIP_VER   = 8'hA0;
    localparam logic [7:0] VER_KEEP   = 8'h40;
    localparam logic [7:0] CTL_KEEP   = 8'h7F;

    // Reset value of indirect register i.
    function automatic logic [7:0] ind_reset_val(input int i);
        if (i == IDX_VER)       return CODEC_VER;
        else if (i == IDX_RO_B) return CHIP_VER;
        else                    return 8'h00;
    endfunction
endpackage

// File: rtl/codec_rf_direct.sv
// Bank of direct words. Word 1 holds no storage because reads go to the
// indirect bank. Word 2 is constant zero. Word 4 masks its writes, and a
// write there takes priority over the software clear on the same edge.
// Assumes soft_clr is only raised during a write to word 4.
module codec_rf_direct
    import codec_rf_pkg::*;
#(
    parameter int N_WORDS = 16,
    parameter int DATA_W  = 32,
    localparam int SEL_W  = $clog2(N_WORDS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           soft_clr,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_word,
    input  logic [DATA_W-1:0]              wdata,
    output logic [N_WORDS-1:0][DATA_W-1:0] regs_o
);
    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        logic [DATA_W-1:0] q;
        logic              hit;
        assign hit = wr_en && (wr_word == SEL_W'(i));

        if (i == WORD_DATA || i == WORD_RO) begin : g_none
            assign q = '0;
        end else if (i == WORD_CTL) begin : g_ctl
            // Control word: capture masked write, else follow the clear.
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= '0;
                else if (hit)      q <= wdata & DATA_W'(CTL_KEEP);
                else if (soft_clr) q <= '0;
            end
        end else begin : g_plain
            // Plain word: full-width storage.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_clr) q <= '0;
                else if (hit)           q <= wdata;
            end
        end
        assign regs_o[i] = q;
    end
endmodule

// File: rtl/codec_rf_indirect.sv
// Bank of indirect registers behind the index/data pair. Read-only
// indices hold their reset value. The version index keeps a fixed code
// and takes one software bit. Assumes wr_en marks a data-port write.
module codec_rf_indirect
    import codec_rf_pkg::*;
#(
    parameter int N_IND  = 32,
    parameter int IND_W  = 8,
    localparam int IDX_W = $clog2(N_IND)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         soft_clr,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             idx,
    input  logic [IND_W-1:0]             wdata,
    output logic [N_IND-1:0][IND_W-1:0]  regs_o
);
    for (genvar i = 0; i < N_IND; i++) begin : g_ind
        localparam logic [IND_W-1:0] RST = IND_W'(ind_reset_val(i));
        logic [IND_W-1:0] q;
        logic             hit;
        assign hit = wr_en && (idx == IDX_W'(i));

        if (i == IDX_RO_A || i == IDX_RO_B) begin : g_ro
            assign q = RST;
        end else if (i == IDX_VER) begin : g_ver
            // Version register: only the free bit follows software.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_clr) q <= RST;
                else if (hit)           q <= (wdata & IND_W'(VER_KEEP)) | IND_W'(CODEC_VER);
            end
        end else begin : g_rw
            // Ordinary indirect register.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_clr) q <= RST;
                else if (hit)           q <= wdata;
            end
        end
        assign regs_o[i] = q;
    end
endmodule

// File: rtl/codec_rf_rdmux.sv
// Read path: selects a direct word, or the indexed indirect register at
// the data port (zero for the write-only index). Registers the result on
// a read strobe and holds it otherwise.
module codec_rf_rdmux
    import codec_rf_pkg::*;
#(
    parameter int N_WORDS = 16,
    parameter int DATA_W  = 32,
    parameter int N_IND   = 32,
    parameter int IND_W   = 8,
    localparam int SEL_W  = $clog2(N_WORDS),
    localparam int IDX_W  = $clog2(N_IND)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [SEL_W-1:0]               rd_word,
    input  logic [IDX_W-1:0]               idx,
    input  logic [N_WORDS-1:0][DATA_W-1:0] dir_regs,
    input  logic [N_IND-1:0][IND_W-1:0]    ind_regs,
    output logic [DATA_W-1:0]              rdata
);
    logic [DATA_W-1:0] rd_val;

    // Select the value that the current address reads.
    always_comb begin
        if (rd_word == SEL_W'(WORD_DATA)) begin
            if (idx == IDX_W'(IDX_WO)) rd_val = '0;
            else                       rd_val = {{(DATA_W-IND_W){1'b0}}, ind_regs[idx]};
        end else begin
            rd_val = dir_regs[rd_word];
        end
    end

    // Register the selected value on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end
endmodule

// File: rtl/codec_regfile.sv
// Top of the codec register file. Decodes the byte address into a word
// select, forms the indirect index from word 0, raises the software clear
// on a word 4 write with bit 0 set, and ties the interrupt low.
// Assumes at most one access of each kind per cycle.
module codec_regfile
    import codec_rf_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int N_IND   = 32,
    parameter int IND_W   = 8,
    localparam int SEL_W  = ADDR_W - 2,
    localparam int N_WORDS = 1 << SEL_W,
    localparam int IDX_W  = $clog2(N_IND)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o
);
    logic [SEL_W-1:0]               word;
    logic [IDX_W-1:0]               ind_idx;
    logic                           soft_clr;
    logic                           port_wr;
    logic                           unused_lsb;
    logic [N_WORDS-1:0][DATA_W-1:0] dir_regs;
    logic [N_IND-1:0][IND_W-1:0]    ind_regs;

    assign word       = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];
    assign ind_idx    = dir_regs[WORD_INDEX][IDX_W-1:0];
    assign soft_clr   = wr_en && (word == SEL_W'(WORD_CTL)) && wdata[0];
    assign port_wr    = wr_en && (word == SEL_W'(WORD_DATA));
    assign irq_o      = 1'b0;

    codec_rf_direct #(.N_WORDS(N_WORDS), .DATA_W(DATA_W)) u_direct (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_en),
        .wr_word(word), .wdata(wdata), .regs_o(dir_regs)
    );

    codec_rf_indirect #(.N_IND(N_IND), .IND_W(IND_W)) u_indirect (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(port_wr),
        .idx(ind_idx), .wdata(wdata[IND_W-1:0]), .regs_o(ind_regs)
    );

    codec_rf_rdmux #(.N_WORDS(N_WORDS), .DATA_W(DATA_W), .N_IND(N_IND), .IND_W(IND_W)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_word(word), .idx(ind_idx),
        .dir_regs(dir_regs), .ind_regs(ind_regs), .rdata(rdata)
    );
endmodule

// File: rtl/codec_regfile_chk.sv
// Checker for codec_regfile. It watches the bus ports and the index
// formed inside the top, and checks the fixed read rules one cycle later.
module codec_regfile_chk
    import codec_rf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-3:0] word;
    assign word = addr[ADDR_W-1:2];

    // R9: rdata holds while no read is issued
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R7: word 2 always reads zero
    a_r7_ro_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word == (ADDR_W-2)'(WORD_RO)) |=> (rdata == '0));

    // R3: write-only index reads zero
    a_r3_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word == (ADDR_W-2)'(WORD_DATA) && idx == IDX_W'(IDX_WO)) |=> (rdata == '0));

    // R5: version register keeps its code
    a_r5_ver_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word == (ADDR_W-2)'(WORD_DATA) && idx == IDX_W'(IDX_VER))
        |=> ((rdata & ~DATA_W'(VER_KEEP)) == DATA_W'(CODEC_VER)));

    // R4: read-only chip version never changes
    a_r4_chip_ver: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word == (ADDR_W-2)'(WORD_DATA) && idx == IDX_W'(IDX_RO_B))
        |=> (rdata == DATA_W'(CHIP_VER)));

    // R8: control word never holds bits above the mask
    a_r8_ctl_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word == (ADDR_W-2)'(WORD_CTL)) |=> ((rdata & ~DATA_W'(CTL_KEEP)) == '0));
endmodule

bind codec_regfile codec_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata), .idx(ind_idx)
);

// File: tb/codec_regfile_tb_top.sv
// Directed bench for codec_regfile: one task per scenario.
module codec_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #2 clk = ~clk;

    codec_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int w, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 6'(w << 2); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int w, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = 6'(w << 2);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd_ind(input int idx, output logic [31:0] d);
        wr(0, 32'(idx));
        rd(1, d);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R6 rdata after reset", rdata, 32'h0);
        check("R10 irq low", {31'b0, irq_o}, 32'h0);
        rd(3, v);  check("R6 word3 reset", v, 0);
        rd(15, v); check("R6 word15 reset", v, 0);
        rd(4, v);  check("R6 word4 reset", v, 0);
        rd(0, v);  check("R6 word0 reset", v, 0);
        rd_ind(12, v); check("R6 ind12 reset", v, 32'h8A);
        rd_ind(25, v); check("R6 ind25 reset", v, 32'hA0);
        rd_ind(7, v);  check("R6 ind7 reset", v, 0);
    endtask

    task automatic t_direct();
        logic [31:0] v;
        wr(3, 32'hDEADBEEF); rd(3, v); check("R1 word3", v, 32'hDEADBEEF);
        wr(15, 32'h0BADF00D); rd(15, v); check("R1 word15", v, 32'h0BADF00D);
        wr(0, 32'hFFFFFFE5); rd(0, v); check("R2 word0 full width", v, 32'hFFFFFFE5);
    endtask

    task automatic t_indirect();
        logic [31:0] v;
        foreach (v[i]) begin end
        for (int k = 0; k < 3; k++) begin
            int idx = (k == 0) ? 0 : (k == 1) ? 5 : 31;
            wr(0, 32'(idx));
            wr(1, 32'hABCD_0000 | 32'(idx * 7 + 8'h11));
            rd(1, v);
            check("R2 indirect rw", v, 32'(8'(idx * 7 + 8'h11)));
        end
        // upper index bits of word 0 are not part of the index
        wr(0, 32'hFFFF_FFE5);
        rd(1, v); check("R2 index low bits", v, 32'h0000_0034);
    endtask

    task automatic t_access_rules();
        logic [31:0] v;
        wr(0, 3); wr(1, 32'h55); rd(1, v); check("R3 write-only reads zero", v, 0);
        wr(0, 11); wr(1, 32'h77); rd(1, v); check("R4 idx11 ignores write", v, 0);
        wr(0, 25); wr(1, 32'h12); rd(1, v); check("R4 idx25 ignores write", v, 32'hA0);
        wr(0, 12); wr(1, 32'hFF); rd(1, v); check("R5 ver bit set", v, 32'hCA);
        wr(1, 32'h00); rd(1, v); check("R5 ver bit clear", v, 32'h8A);
        wr(2, 32'h1234); rd(2, v); check("R7 word2 ignores write", v, 0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        wr(3, 32'h1111); wr(0, 5); wr(1, 32'h33); wr(0, 12); wr(1, 32'h40);
        wr(4, 32'hFFFF_FF81);
        rd(4, v); check("R8 ctl keeps masked write", v, 32'h01);
        rd(3, v); check("R8 word3 cleared", v, 0);
        rd(0, v); check("R8 word0 cleared", v, 0);
        rd_ind(5, v);  check("R8 ind5 cleared", v, 0);
        rd_ind(12, v); check("R8 ind12 back to code", v, 32'h8A);
        wr(3, 32'h2222);
        wr(4, 32'h0000_00FE);
        rd(4, v); check("R8 ctl no reset", v, 32'h7E);
        rd(3, v); check("R8 bit0 clear keeps word3", v, 32'h2222);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        wr(3, 32'hAAAA_0001);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 6'd12; wdata = 32'hBBBB_0002;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R9 read-during-write old value", rdata, 32'hAAAA_0001);
        repeat (3) @(negedge clk);
        check("R9 rdata holds while idle", rdata, 32'hAAAA_0001);
        rd(3, v); check("R9 new value next read", v, 32'hBBBB_0002);
        check("R10 irq still low", {31'b0, irq_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_indirect();
        t_access_rules();
        t_soft_reset();
        t_timing();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule